// File: doc/BRIEF.md
# Two-bit JK-excited state machine

This block is a small clocked sequential machine with two state bits, A and B, and one serial input bit. Each state bit sits in its own behavioural JK-style register. The J and K inputs of both registers come from fixed cross-coupled equations of the present state and the input:

- J of A is B.
- K of A is B and not x.
- J of B is not x.
- K of B is A xor x.

The transition table of the machine is therefore not written out in the design. It follows from these equations and from the usual JK register behaviour.

Both state bits are brought out as outputs. There is no separate output function. The machine updates on every rising clock edge, and the input is sampled at that edge. An active-high synchronous reset returns it to state 00.

Top module: `jk_pair_fsm`

## Requirements
- R1: When `rst` is 1 at a rising edge, both `st_a` and `st_b` are 0 after that edge, whatever `x_in` and the present state are. Reset takes priority over the JK update.
- R2: From state {A,B}=00, `x_in`=0 moves the machine to 01, and `x_in`=1 keeps it at 00.
- R3: From state 01, `x_in`=0 moves the machine to 11, and `x_in`=1 moves it to 10.
- R4: From state 10, `x_in`=0 moves the machine to 11, and `x_in`=1 keeps it at 10.
- R5: From state 11, `x_in`=0 moves the machine to 00, and `x_in`=1 keeps it at 11.
- R6: Whenever B is 0 before an edge, both J and K of A are 0. Bit A then keeps its value across that edge (JK hold).
- R7: Whenever `x_in` is 0 and A is 0 before an edge, J of B is 1 and K of B is 0. Bit B is then 1 after that edge (JK set).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| x_in | input | 1 | Serial input bit, sampled at the rising edge |
| st_a | output | 1 | State bit A |
| st_b | output | 1 | State bit B |

## Verification
Both state bits are outputs, so a wrong excitation term shows up on `st_a` or `st_b` at the first rising edge where that term matters. No later output has to be waited for.

Every one of the eight state and input pairs is reached from reset and compared with an independent table. A long pseudo-random input walk then compares the outputs with a table model after every edge. A swapped equation or a wrong JK decode is therefore caught within one cycle of the first pair it affects.

// File: rtl/jk_pair_fsm.sv
module jk_pair_fsm (
  input  logic clk,
  input  logic rst,
  input  logic x_in,
  output logic st_a,
  output logic st_b
);

  function automatic logic jk_step(input logic q, input logic j, input logic k);
    case ({j, k})
      2'b00:   jk_step = q;
      2'b01:   jk_step = 1'b0;
      2'b10:   jk_step = 1'b1;
      default: jk_step = ~q;
    endcase
  endfunction

  logic j_a, k_a, j_b, k_b;

  assign j_a = st_b;
  assign k_a = st_b & ~x_in;
  assign j_b = ~x_in;
  assign k_b = st_a ^ x_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_a <= 1'b0;
      st_b <= 1'b0;
    end else begin
      st_a <= jk_step(st_a, j_a, k_a);
      st_b <= jk_step(st_b, j_b, k_b);
    end
  end

endmodule

// File: rtl/jk_pair_fsm_chk.sv
module jk_pair_fsm_chk (
  input logic clk,
  input logic rst,
  input logic x_in,
  input logic st_a,
  input logic st_b
);

  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  always @(negedge clk)
    if (rst_q) assert_reset_zero_R1: assert (!st_a && !st_b);

  assert_from00_R2: assert property (@(posedge clk) disable iff (rst)
    (!st_a && !st_b) |=> (st_a == 1'b0 && st_b == !$past(x_in)));

  assert_from01_R3: assert property (@(posedge clk) disable iff (rst)
    (!st_a && st_b) |=> (st_a && st_b == !$past(x_in)));

  assert_from10_R4: assert property (@(posedge clk) disable iff (rst)
    (st_a && !st_b) |=> (st_a && st_b == !$past(x_in)));

  assert_from11_R5: assert property (@(posedge clk) disable iff (rst)
    (st_a && st_b) |=> (st_a == $past(x_in) && st_b == $past(x_in)));

  assert_a_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !st_b |=> $stable(st_a));

  assert_b_set_R7: assert property (@(posedge clk) disable iff (rst)
    (!x_in && !st_a) |=> st_b);

endmodule

bind jk_pair_fsm jk_pair_fsm_chk u_chk (.*);

// File: tb/jk_pair_fsm_test.sv
module jk_pair_fsm_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x_in = 1'b0;
  logic st_a, st_b;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  jk_pair_fsm uut (.clk(clk), .rst(rst), .x_in(x_in), .st_a(st_a), .st_b(st_b));

  // {A, B, x, next A, next B}
  localparam logic [4:0] VEC [0:7] = '{
    5'b000_01, 5'b001_00, 5'b010_11, 5'b011_10,
    5'b100_11, 5'b101_10, 5'b110_00, 5'b111_11
  };

  function automatic logic [1:0] model(input logic [1:0] s, input logic x);
    case ({s, x})
      3'b000: model = 2'b01;
      3'b001: model = 2'b00;
      3'b010: model = 2'b11;
      3'b011: model = 2'b10;
      3'b100: model = 2'b11;
      3'b101: model = 2'b10;
      3'b110: model = 2'b00;
      default: model = 2'b11;
    endcase
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic x);
    @(negedge clk);
    rst = r;
    x_in = x;
    @(posedge clk);
    #1;
  endtask

  task automatic go_to(input logic [1:0] s);
    step(1'b1, 1'b0);
    case (s)
      2'b01: step(1'b0, 1'b0);
      2'b10: begin step(1'b0, 1'b0); step(1'b0, 1'b1); end
      2'b11: begin step(1'b0, 1'b0); step(1'b0, 1'b0); end
      default: ;
    endcase
  endtask

  initial begin
    string tag;
    logic [7:0] lfsr;
    logic [1:0] prev;

    step(1'b1, 1'b1);
    check("R1 reset state", {st_a, st_b}, 2'b00);

    for (int i = 0; i < 8; i++) begin
      go_to(VEC[i][4:3]);
      check("setup", {st_a, st_b}, VEC[i][4:3]);
      step(1'b0, VEC[i][2]);
      case (VEC[i][4:3])
        2'b00: tag = "R2";
        2'b01: tag = "R3";
        2'b10: tag = "R4";
        default: tag = "R5";
      endcase
      check(tag, {st_a, st_b}, VEC[i][1:0]);
    end

    // R1 priority: from 10 with x=1 the machine would stay at 10
    go_to(2'b10);
    step(1'b1, 1'b1);
    check("R1 priority over hold in 10", {st_a, st_b}, 2'b00);

    // R1 priority: from 00 with x=0 the machine would go to 01
    step(1'b1, 1'b0);
    check("R1 priority over set in 00", {st_a, st_b}, 2'b00);

    // R1 priority: from 11 with x=1 the machine would stay at 11
    go_to(2'b11);
    step(1'b1, 1'b1);
    check("R1 priority over hold in 11", {st_a, st_b}, 2'b00);

    // R2-R7: pseudo-random input walk against the table model
    step(1'b1, 1'b0);
    lfsr = 8'hA5;
    for (int n = 0; n < 400; n++) begin
      prev = {st_a, st_b};
      step(1'b0, lfsr[0]);
      check("R2-R5 walk", {st_a, st_b}, model(prev, lfsr[0]));
      if (!prev[0]) check("R6 A holds", {1'b0, st_a}, {1'b0, prev[1]});
      if (!lfsr[0] && !prev[1]) check("R7 B set", {1'b0, st_b}, 2'b01);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule